// File: doc/BRIEF.md
# Key-Unlocked Index/Data Configuration Port

This block answers on a two-byte I/O window. The lower address holds an index register and the upper address is the data window. After reset the window is locked. It opens only when the key byte 0x87 is written to the index address on two consecutive index writes. A later write of 0xAA to the index address locks it again. While the window is open, an index write chooses a configuration register, and data-port reads and writes reach that register.

The block holds three kinds of register:
- a global logical-device number;
- read-only identification bytes;
- a forwarding path for indexes 0x30 and above. On that path the block drives read and write strobes, the current index and the logical-device number to the selected device. Forwarded reads return data in the same cycle.

A strap parameter places the window at base 0x2E or 0x4E.

The lock controller has three states. In LOCKED it waits for the first key. In KEY_SEEN it waits for the second key. In OPEN configuration access is allowed. It has five transitions:
- FIRST_KEY: LOCKED to KEY_SEEN, on an index write of 0x87.
- SECOND_KEY: KEY_SEEN to OPEN, on an index write of 0x87.
- BAD_KEY: KEY_SEEN to LOCKED, on an index write of any other value.
- LOCK_BYTE: OPEN to LOCKED, on an index write of 0xAA.
- HOLD: the state is kept for every other access.

Top module: `cfg_port`

## Requirements
- R1: The block responds only at addresses BASE and BASE+1. BASE is 0x2E when ALT_BASE=0 and 0x4E when ALT_BASE=1. At any other address, writes have no effect and reads return 0xFF.
- R2: Configuration access opens only after two consecutive index writes of 0x87.
- R3: In KEY_SEEN, an index write of any value other than 0x87 returns the block to LOCKED. A later single key byte then does not open access.
- R4: In OPEN, an index write of 0xAA returns the block to LOCKED.
- R5: While not OPEN, data-port and index-port reads return 0xFF, data-port writes change nothing, and no forwarding strobe is driven.
- R6: In OPEN, an index write other than 0xAA latches the index. The index keeps its value across data accesses, and an index-port read returns it.
- R7: Index 0x07 is a read/write logical-device number that resets to 0x00.
- R8: Indexes 0x20 and 0x21 read the device ID high and low bytes. Index 0x22 reads the revision byte. Indexes 0x23 and 0x24 read 0x19 and 0x34. Writes to these indexes change nothing.
- R9: At indexes 0x30 and above, a data write drives dev_wr with the index, the logical-device number and the write byte. A data read drives dev_rd and returns dev_rdata in the same cycle.
- R10: Data-port reads at undefined indexes below 0x30 return 0xFF and drive no forwarding strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, valid in the cycle of io_rd |
| dev_wr | output | 1 | Forwarded register write |
| dev_rd | output | 1 | Forwarded register read |
| dev_idx | output | 8 | Forwarded register index |
| dev_ld | output | 8 | Current logical-device number |
| dev_wdata | output | 8 | Forwarded write byte |
| dev_rdata | input | 8 | Read byte returned by the device |

## Verification
The unlock sequence is tried in three forms:
- a clean pair of keys, which must open access;
- a key followed by a stray byte and then a single key, which tells a sequence that restarts from one that only counts keys;
- a lock byte after opening.

Data accesses are sent to the logical-device register, the identification bytes, an undefined low index and forwarded high indexes. A forwarded read returns a pattern that mixes the index and the device number, so a wrong index or a wrong device number is caught. Accesses at the other base address and while locked show that the block ignores them and leaves its state unchanged.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_KEY_SEEN = 2'd1,
        ST_OPEN     = 2'd2
    } lock_state_t;

    localparam logic [7:0] KEY_BYTE  = 8'h87;
    localparam logic [7:0] LOCK_BYTE = 8'hAA;
    localparam logic [7:0] IDX_LDN   = 8'h07;
    localparam logic [7:0] IDX_DID_H = 8'h20;
    localparam logic [7:0] IDX_DID_L = 8'h21;
    localparam logic [7:0] IDX_REV   = 8'h22;
    localparam logic [7:0] IDX_VID_H = 8'h23;
    localparam logic [7:0] IDX_VID_L = 8'h24;
    localparam logic [7:0] IDX_FWD   = 8'h30;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
    import cfg_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        idx_wr,
    input  logic [7:0]  wdata,
    output lock_state_t state,
    output logic        open
);
    lock_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCKED:   if (idx_wr && wdata == KEY_BYTE) state_nx = ST_KEY_SEEN;
            ST_KEY_SEEN: if (idx_wr) state_nx = (wdata == KEY_BYTE) ? ST_OPEN : ST_LOCKED;
            ST_OPEN:     if (idx_wr && wdata == LOCK_BYTE) state_nx = ST_LOCKED;
            default:     state_nx = ST_LOCKED;
        endcase
    end

    always_comb begin
        open = (state == ST_OPEN);
    end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import cfg_port_pkg::*;
#(
    parameter int         DW     = 8,
    parameter logic [15:0] DEV_ID = 16'h0541,
    parameter logic [7:0]  REV_ID = 8'h10,
    parameter logic [15:0] VEN_ID = 16'h1934
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open,
    input  logic          idx_wr,
    input  logic          dat_wr,
    input  logic          dat_rd,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] fwd_rdata,
    output logic [DW-1:0] index_q,
    output logic [DW-1:0] ld_q,
    output logic [DW-1:0] reg_rdata,
    output logic          fwd_wr,
    output logic          fwd_rd
);
    logic fwd_zone;

    always_comb fwd_zone = (index_q >= IDX_FWD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q <= '0;
            ld_q    <= '0;
        end else begin
            if (open && idx_wr && wdata != LOCK_BYTE) index_q <= wdata;
            if (open && dat_wr && index_q == IDX_LDN) ld_q <= wdata;
        end
    end

    always_comb begin
        fwd_wr = open && dat_wr && fwd_zone;
        fwd_rd = open && dat_rd && fwd_zone;
        if (fwd_zone) begin
            reg_rdata = fwd_rdata;
        end else begin
            unique case (index_q)
                IDX_LDN:   reg_rdata = ld_q;
                IDX_DID_H: reg_rdata = DEV_ID[15:8];
                IDX_DID_L: reg_rdata = DEV_ID[7:0];
                IDX_REV:   reg_rdata = REV_ID;
                IDX_VID_H: reg_rdata = VEN_ID[15:8];
                IDX_VID_L: reg_rdata = VEN_ID[7:0];
                default:   reg_rdata = IDLE_BYTE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_port.sv
module cfg_port
    import cfg_port_pkg::*;
#(
    parameter int         AW       = 16,
    parameter bit         ALT_BASE = 1'b0,
    parameter logic [15:0] DEV_ID  = 16'h0541,
    parameter logic [7:0]  REV_ID  = 8'h10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [7:0]    io_wdata,
    output logic [7:0]    io_rdata,
    output logic          dev_wr,
    output logic          dev_rd,
    output logic [7:0]    dev_idx,
    output logic [7:0]    dev_ld,
    output logic [7:0]    dev_wdata,
    input  logic [7:0]    dev_rdata
);
    localparam logic [AW-1:0] BASE = ALT_BASE ? AW'(16'h004E) : AW'(16'h002E);

    logic        hit, idx_wr, dat_wr, dat_rd, open;
    lock_state_t state;
    logic [7:0]  index_q, ld_q, reg_rdata;

    always_comb begin
        hit    = (io_addr[AW-1:1] == BASE[AW-1:1]);
        idx_wr = hit && io_wr && !io_addr[0];
        dat_wr = hit && io_wr &&  io_addr[0];
        dat_rd = hit && io_rd &&  io_addr[0];
    end

    cfg_lock_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .idx_wr(idx_wr),
        .wdata (io_wdata),
        .state (state),
        .open  (open)
    );

    cfg_regs #(.DW(8), .DEV_ID(DEV_ID), .REV_ID(REV_ID)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .open     (open),
        .idx_wr   (idx_wr),
        .dat_wr   (dat_wr),
        .dat_rd   (dat_rd),
        .wdata    (io_wdata),
        .fwd_rdata(dev_rdata),
        .index_q  (index_q),
        .ld_q     (ld_q),
        .reg_rdata(reg_rdata),
        .fwd_wr   (dev_wr),
        .fwd_rd   (dev_rd)
    );

    always_comb begin
        dev_idx   = index_q;
        dev_ld    = ld_q;
        dev_wdata = io_wdata;
        io_rdata  = IDLE_BYTE;
        if (hit && io_rd && open)
            io_rdata = io_addr[0] ? reg_rdata : index_q;
    end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk
    import cfg_port_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_wr,
    input logic        io_rd,
    input logic [7:0]  io_wdata,
    input logic [7:0]  io_rdata,
    input logic        dev_wr,
    input logic        dev_rd,
    input logic [7:0]  dev_idx,
    input lock_state_t state,
    input logic [7:0]  ld_q,
    input logic        hit
);
    // R2
    key_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && $past(state) != ST_OPEN) |->
        ($past(state) == ST_KEY_SEEN && $past(io_wdata) == KEY_BYTE && $past(io_wr)));

    // R4
    lock_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && hit && io_wr && !io_addr[0] && io_wdata == LOCK_BYTE)
        |=> state == ST_LOCKED);

    // R5
    locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OPEN && io_rd) |-> io_rdata == IDLE_BYTE);

    // R5
    locked_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OPEN) |-> !(dev_wr || dev_rd));

    // R7
    ldn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_OPEN && hit && io_wr && io_addr[0] && dev_idx == IDX_LDN)
        |=> $stable(ld_q));

    // R9
    fwd_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr || dev_rd) |-> dev_idx >= IDX_FWD);

    // R8
    vendor_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && hit && io_rd && io_addr[0] && dev_idx == IDX_VID_H)
        |-> io_rdata == 8'h19);
endmodule

bind cfg_port cfg_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .io_wdata(io_wdata),
    .io_rdata(io_rdata),
    .dev_wr  (dev_wr),
    .dev_rd  (dev_rd),
    .dev_idx (dev_idx),
    .state   (state),
    .ld_q    (ld_q),
    .hit     (hit)
);

// File: tb/cfg_port_tb.sv
module cfg_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic        dev_wr, dev_rd;
    logic [7:0]  dev_idx, dev_ld, dev_wdata, dev_rdata;

    int tests = 0, fails = 0;
    int wr_count = 0;
    logic [7:0] last_idx, last_ld, last_data;
    logic [7:0] rb;

    localparam logic [15:0] IDX = 16'h002E;
    localparam logic [15:0] DAT = 16'h002F;

    always #2 clk = ~clk;

    assign dev_rdata = {dev_ld[3:0], dev_idx[3:0]} ^ 8'h5A;

    always @(posedge clk) if (dev_wr) begin
        wr_count  <= wr_count + 1;
        last_idx  <= dev_idx;
        last_ld   <= dev_ld;
        last_data <= dev_wdata;
    end

    cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_wr(dev_wr), .dev_rd(dev_rd),
        .dev_idx(dev_idx), .dev_ld(dev_ld), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic strobe);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata; strobe = dev_rd;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] i, output logic [7:0] d);
        logic s;
        wr(IDX, i);
        rd(DAT, d, s);
    endtask

    task automatic t_reset_locked();
        logic s;
        rd(DAT, rb, s);
        check("R5 locked data read", rb, 8'hFF);
        rd(IDX, rb, s);
        check("R5 locked index read", rb, 8'hFF);
        wr(IDX, 8'h07);
        wr(DAT, 8'h33);
        check("R5 no forward while locked", wr_count, 0);
    endtask

    task automatic t_bad_sequence();
        logic s;
        wr(IDX, 8'h87); wr(IDX, 8'h55); wr(IDX, 8'h87);
        wr(IDX, 8'h07);
        rd(DAT, rb, s);
        check("R3 broken key stays locked", rb, 8'hFF);
    endtask

    task automatic t_unlock_ids();
        wr(IDX, 8'h87); wr(IDX, 8'h87);
        rreg(8'h07, rb); check("R7 ldn reset 0, R5 locked write ignored", rb, 8'h00);
        rreg(8'h20, rb); check("R8 devid hi", rb, 8'h05);
        rreg(8'h21, rb); check("R8 devid lo", rb, 8'h41);
        rreg(8'h22, rb); check("R8 revision", rb, 8'h10);
        rreg(8'h23, rb); check("R2 R8 vendor hi", rb, 8'h19);
        rreg(8'h24, rb); check("R8 vendor lo", rb, 8'h34);
        wr(DAT, 8'h00);
        rreg(8'h24, rb); check("R8 id write ignored", rb, 8'h34);
    endtask

    task automatic t_ldn_index();
        logic s;
        wr(IDX, 8'h07); wr(DAT, 8'h06);
        rd(DAT, rb, s); check("R7 ldn readback", rb, 8'h06);
        rd(DAT, rb, s); check("R6 index held", rb, 8'h06);
        rd(IDX, rb, s); check("R6 index port read", rb, 8'h07);
    endtask

    task automatic t_forward();
        logic s;
        wr(IDX, 8'h31); wr(DAT, 8'hC3);
        check("R9 fwd write count", wr_count, 1);
        check("R9 fwd write idx", last_idx, 8'h31);
        check("R9 fwd write ld", last_ld, 8'h06);
        check("R9 fwd write data", last_data, 8'hC3);
        wr(IDX, 8'h35);
        rd(DAT, rb, s);
        check("R9 fwd read data", rb, 8'h65 ^ 8'h5A);
        check("R9 fwd read strobe", s, 1);
        wr(IDX, 8'h10);
        rd(DAT, rb, s);
        check("R10 undefined read", rb, 8'hFF);
        check("R10 no strobe", s, 0);
    endtask

    task automatic t_other_base();
        logic s;
        wr(IDX, 8'h07);
        wr(16'h004E, 8'h22); wr(16'h004F, 8'h09);
        rd(16'h004F, rb, s); check("R1 other base read", rb, 8'hFF);
        rd(DAT, rb, s); check("R1 other base write ignored", rb, 8'h06);
    endtask

    task automatic t_lock();
        logic s;
        wr(IDX, 8'hAA);
        rd(DAT, rb, s); check("R4 locked after AA", rb, 8'hFF);
        wr(IDX, 8'h31); wr(DAT, 8'h11);
        check("R4 R5 no forward after lock", wr_count, 1);
        wr(IDX, 8'h87); wr(IDX, 8'h87);
        rd(IDX, rb, s); check("R4 index kept while locked", rb, 8'h07);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset_locked();
                t_bad_sequence();
                t_unlock_ids();
                t_ldn_index();
                t_forward();
                t_other_base();
                t_lock();
            end
            begin
                repeat (5000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule